// File: doc/BRIEF.md
# Storage Controller Enable and Shutdown Handshake

This block is the device-side model of a storage controller's configuration and status words, reached over a simple 32-bit register bus. The host turns the controller on by setting an enable bit in the configuration word. After a programmable latency, the block raises a ready flag in the status word. When the host clears enable, ready drops after a second programmable latency.

A host can also ask the controller to shut down, either in the normal way or abruptly, through a two-bit request field in the configuration word. The status word then shows a shutdown field that moves from "normal" to "in progress" and later to "complete". The time spent in progress is set by a parameter for each request kind. A fresh enable returns the shutdown status to normal.

A separate boot word reads as zero until an internal boot delay has elapsed after reset. From then on it reads as a fixed signature. Host firmware polls this word before it touches the controller. Reads return their data one cycle after the request. Any offset the block does not decode reads as zero.

Top module: `ctrl_handshake`

## Requirements
- R1: After a synchronous reset, the configuration word (offset 0x14), the status word (offset 0x1C) and the boot word (offset 0x1300) all read as zero.
- R2: A read request (bus_sel=1, bus_wr=0) produces rsp_valid=1 on the following cycle, carrying the word the register held before that edge. rsp_data is zero whenever rsp_valid is low. Every offset other than 0x14, 0x1C and 0x1300 reads as zero.
- R3: A write to 0x14 stores bit 0 as enable and bits 15:14 as the shutdown request (0 none, 1 normal, 2 abrupt, 3 reserved). All other bits of that word read back as zero.
- R4: While the shutdown request is 0 and shutdown is not in progress, enable=1 makes status bit 0 (ready) read 1 from the edge that lies EN_LAT+1 cycles after the edge that took the write.
- R5: Clearing enable while ready is 1 makes ready read 0 from the edge that lies DIS_LAT+1 cycles after the write. Setting enable again before then leaves ready at 1.
- R6: Ready never rises while the shutdown status is "in progress" (status bits 3:2 = 1). A pending rise is abandoned if enable is cleared or the shutdown request becomes nonzero.
- R7: A request value of 1 (normal), written while the status is normal, sets status bits 3:2 to 1 from the edge after the write. SHN_LAT cycles later they become 2 (complete) and stay there. Ready, if already 1, is unaffected.
- R8: A request value of 2 (abrupt) follows the same sequence but stays in progress for ABRT_LAT cycles. A request value of 3 starts no shutdown.
- R9: A write that moves enable from 0 to 1 with the request at 0 returns the shutdown status to 0 (normal) on the edge after the write.
- R10: The boot word at 0x1300 reads 0xDE71CE55 once BOOT_LAT clock edges have passed since reset, and reads zero before that.
- R11: Writes to the status word, the boot word and undecoded offsets change nothing that can be read back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access request this cycle |
| bus_wr | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after a read request |
| rsp_data | output | 32 | Read data, zero when rsp_valid is low |

## Verification
The hardest situations to reach are those in which a host action lands inside one of the timed windows. Examples are a re-enable one or two cycles into the falling window, a disable during the rising window, and a shutdown request written while ready is still rising. Each of these has to meet the sequencer in one particular cycle. The bench therefore overrides the latencies with small values and places writes a fixed number of cycles after one another. It reads the status word back to back on every cycle, so that a cycle-accurate reference model checks the exact edge at which each field changes.

// File: rtl/ctrl_hs_pkg.sv
package ctrl_hs_pkg;

    localparam int DATA_W = 32;

    // byte offsets decoded by the register bank
    localparam logic [15:0] OFS_CFG  = 16'h0014;
    localparam logic [15:0] OFS_STS  = 16'h001C;
    localparam logic [15:0] OFS_BOOT = 16'h1300;

    localparam logic [DATA_W-1:0] BOOT_SIGNATURE = 32'hDE71_CE55;

    // bit positions shared by host software and the model
    localparam int CFG_EN_BIT  = 0;
    localparam int CFG_REQ_LSB = 14;
    localparam int STS_RDY_BIT = 0;
    localparam int STS_SH_LSB  = 2;

    typedef enum logic [1:0] {
        REQ_NONE   = 2'd0,
        REQ_NORMAL = 2'd1,
        REQ_ABRUPT = 2'd2,
        REQ_RSVD   = 2'd3
    } sd_req_e;

    typedef enum logic [1:0] {
        SH_NORMAL = 2'd0,
        SH_BUSY   = 2'd1,
        SH_DONE   = 2'd2
    } sd_state_e;

    typedef enum logic [1:0] {
        RS_OFF,
        RS_RISE,
        RS_ON,
        RS_FALL
    } rdy_state_e;

    typedef struct packed {
        logic    en;
        sd_req_e req;
    } cfg_t;

    function automatic logic [DATA_W-1:0] cfg_word(cfg_t c);
        logic [DATA_W-1:0] w;
        w = '0;
        w[CFG_EN_BIT] = c.en;
        w[CFG_REQ_LSB +: 2] = c.req;
        return w;
    endfunction

    function automatic logic [DATA_W-1:0] sts_word(logic rdy, sd_state_e s);
        logic [DATA_W-1:0] w;
        w = '0;
        w[STS_RDY_BIT] = rdy;
        w[STS_SH_LSB +: 2] = s;
        return w;
    endfunction

endpackage

// File: rtl/hs_regbank.sv
module hs_regbank
    import ctrl_hs_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              rdy,
    input  sd_state_e         shst,
    input  logic              boot_done,
    output cfg_t              cfg,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data
);

    localparam logic [ADDR_W-1:0] A_CFG  = ADDR_W'(OFS_CFG);
    localparam logic [ADDR_W-1:0] A_STS  = ADDR_W'(OFS_STS);
    localparam logic [ADDR_W-1:0] A_BOOT = ADDR_W'(OFS_BOOT);

    logic              rd_req;
    logic              cfg_we;
    logic [DATA_W-1:0] rd_word;
    logic              unused_wbits;

    assign rd_req = bus_sel && !bus_wr;
    assign cfg_we = bus_sel && bus_wr && (bus_addr == A_CFG);
    assign unused_wbits = ^{bus_wdata[DATA_W-1:CFG_REQ_LSB+2],
                            bus_wdata[CFG_REQ_LSB-1:CFG_EN_BIT+1]};

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '{en: 1'b0, req: REQ_NONE};
        end else if (cfg_we) begin
            cfg.en  <= bus_wdata[CFG_EN_BIT];
            cfg.req <= sd_req_e'(bus_wdata[CFG_REQ_LSB +: 2]);
        end
    end

    always_comb begin
        rd_word = '0;
        if (bus_addr == A_CFG)       rd_word = cfg_word(cfg);
        else if (bus_addr == A_STS)  rd_word = sts_word(rdy, shst);
        else if (bus_addr == A_BOOT) rd_word = boot_done ? BOOT_SIGNATURE : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
        end else begin
            rsp_valid <= rd_req;
            rsp_data  <= rd_req ? rd_word : '0;
        end
    end

endmodule

// File: rtl/hs_ready_seq.sv
module hs_ready_seq
    import ctrl_hs_pkg::*;
#(
    parameter int EN_LAT  = 16,
    parameter int DIS_LAT = 8
) (
    input  logic      clk,
    input  logic      rst,
    input  cfg_t      cfg,
    input  sd_state_e shst,
    output logic      rdy
);

    localparam int MAX_LAT = (EN_LAT > DIS_LAT) ? EN_LAT : DIS_LAT;
    localparam int CW      = $clog2(MAX_LAT + 1);

    rdy_state_e    state;
    logic [CW-1:0] cnt;
    logic          may_rise;

    // a rise is only allowed with no request pending and no shutdown running
    assign may_rise = cfg.en && (cfg.req == REQ_NONE) && (shst != SH_BUSY);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= RS_OFF;
            cnt   <= '0;
        end else begin
            unique case (state)
                RS_OFF: if (may_rise) begin
                    state <= RS_RISE;
                    cnt   <= CW'(EN_LAT - 1);
                end
                RS_RISE: begin
                    if (!may_rise)      state <= RS_OFF;
                    else if (cnt == '0) state <= RS_ON;
                    else                cnt   <= cnt - 1'b1;
                end
                RS_ON: if (!cfg.en) begin
                    state <= RS_FALL;
                    cnt   <= CW'(DIS_LAT - 1);
                end
                RS_FALL: begin
                    if (cfg.en)         state <= RS_ON;
                    else if (cnt == '0) state <= RS_OFF;
                    else                cnt   <= cnt - 1'b1;
                end
                default: state <= RS_OFF;
            endcase
        end
    end

    assign rdy = (state == RS_ON) || (state == RS_FALL);

endmodule

// File: rtl/hs_shutdown_seq.sv
module hs_shutdown_seq
    import ctrl_hs_pkg::*;
#(
    parameter int SHN_LAT  = 32,
    parameter int ABRT_LAT = 4
) (
    input  logic      clk,
    input  logic      rst,
    input  cfg_t      cfg,
    output sd_state_e shst
);

    localparam int MAX_LAT = (SHN_LAT > ABRT_LAT) ? SHN_LAT : ABRT_LAT;
    localparam int CW      = $clog2(MAX_LAT + 1);

    logic          en_d1;
    logic          fresh_enable;
    logic [CW-1:0] cnt;

    assign fresh_enable = cfg.en && !en_d1 && (cfg.req == REQ_NONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            en_d1 <= 1'b0;
            shst  <= SH_NORMAL;
            cnt   <= '0;
        end else begin
            en_d1 <= cfg.en;
            if (fresh_enable) begin
                shst <= SH_NORMAL;
            end else begin
                unique case (shst)
                    SH_NORMAL: begin
                        if (cfg.req == REQ_NORMAL) begin
                            shst <= SH_BUSY;
                            cnt  <= CW'(SHN_LAT - 1);
                        end else if (cfg.req == REQ_ABRUPT) begin
                            shst <= SH_BUSY;
                            cnt  <= CW'(ABRT_LAT - 1);
                        end
                    end
                    SH_BUSY: begin
                        if (cnt == '0) shst <= SH_DONE;
                        else           cnt  <= cnt - 1'b1;
                    end
                    SH_DONE: shst <= SH_DONE;
                    default: shst <= SH_NORMAL;
                endcase
            end
        end
    end

endmodule

// File: rtl/hs_boot_timer.sv
module hs_boot_timer #(
    parameter int BOOT_LAT = 256
) (
    input  logic clk,
    input  logic rst,
    output logic boot_done
);

    localparam int CW = $clog2(BOOT_LAT + 1);
    localparam logic [CW-1:0] LIMIT = CW'(BOOT_LAT);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)                cnt <= '0;
        else if (cnt != LIMIT)  cnt <= cnt + 1'b1;
    end

    assign boot_done = (cnt == LIMIT);

endmodule

// File: rtl/ctrl_handshake.sv
module ctrl_handshake
    import ctrl_hs_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int EN_LAT   = 16,
    parameter int DIS_LAT  = 8,
    parameter int SHN_LAT  = 32,
    parameter int ABRT_LAT = 4,
    parameter int BOOT_LAT = 256
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic              rsp_valid,
    output logic [31:0]       rsp_data
);

    cfg_t      cfg;
    sd_state_e shst;
    logic      rdy;
    logic      boot_done;

    hs_regbank #(.ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .rdy       (rdy),
        .shst      (shst),
        .boot_done (boot_done),
        .cfg       (cfg),
        .rsp_valid (rsp_valid),
        .rsp_data  (rsp_data)
    );

    hs_ready_seq #(.EN_LAT(EN_LAT), .DIS_LAT(DIS_LAT)) u_ready (
        .clk  (clk),
        .rst  (rst),
        .cfg  (cfg),
        .shst (shst),
        .rdy  (rdy)
    );

    hs_shutdown_seq #(.SHN_LAT(SHN_LAT), .ABRT_LAT(ABRT_LAT)) u_shut (
        .clk  (clk),
        .rst  (rst),
        .cfg  (cfg),
        .shst (shst)
    );

    hs_boot_timer #(.BOOT_LAT(BOOT_LAT)) u_boot (
        .clk       (clk),
        .rst       (rst),
        .boot_done (boot_done)
    );

endmodule

// File: rtl/ctrl_handshake_checker.sv
module ctrl_handshake_checker (
    input logic        clk,
    input logic        rst,
    input logic        sel,
    input logic        wr,
    input logic        rdy,
    input logic [1:0]  shst,
    input logic        cfg_en,
    input logic        boot_done,
    input logic        rsp_valid,
    input logic [31:0] rsp_data
);

    // R2: a read request is answered on the next cycle
    a_r2_read_answered: assert property (@(posedge clk) disable iff (rst)
        (sel && !wr) |=> rsp_valid);

    // R2: no response and zero data without a read request
    a_r2_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !(sel && !wr) |=> (!rsp_valid && rsp_data == 32'd0));

    // R6: ready never rises while shutdown is in progress
    a_r6_no_rise_in_busy: assert property (@(posedge clk) disable iff (rst)
        $rose(rdy) |-> (shst != 2'd1));

    // R4: ready only rises after enable was held
    a_r4_rise_needs_enable: assert property (@(posedge clk) disable iff (rst)
        $rose(rdy) |-> $past(cfg_en));

    // R5: ready only falls after enable was cleared
    a_r5_fall_needs_disable: assert property (@(posedge clk) disable iff (rst)
        $fell(rdy) |-> !$past(cfg_en));

    // R7: shutdown status never jumps from normal straight to complete
    a_r7_no_skip_busy: assert property (@(posedge clk) disable iff (rst)
        ($past(shst) == 2'd0) |-> (shst != 2'd2));

    // R10: once boot has completed it stays completed
    a_r10_boot_sticky: assert property (@(posedge clk) disable iff (rst)
        boot_done |=> boot_done);

endmodule

bind ctrl_handshake ctrl_handshake_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .sel       (bus_sel),
    .wr        (bus_wr),
    .rdy       (rdy),
    .shst      (shst),
    .cfg_en    (cfg.en),
    .boot_done (boot_done),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_data)
);

// File: tb/tb_ctrl_handshake.sv
module tb_ctrl_handshake;

    localparam int EN_LAT   = 5;
    localparam int DIS_LAT  = 3;
    localparam int SHN_LAT  = 6;
    localparam int ABRT_LAT = 2;
    localparam int BOOT_LAT = 20;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [15:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        rsp_valid;
    logic [31:0] rsp_data;

    always #5 clk = ~clk;

    ctrl_handshake #(
        .ADDR_W(16), .EN_LAT(EN_LAT), .DIS_LAT(DIS_LAT),
        .SHN_LAT(SHN_LAT), .ABRT_LAT(ABRT_LAT), .BOOT_LAT(BOOT_LAT)
    ) dut (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data)
    );

    int    n_checks = 0;
    int    n_fail = 0;
    string tag = "R1";
    bit    finished = 0;

    // reference model: countdown timers kept as plain integers
    int m_en, m_req, m_enp, m_rdy, rise_t, fall_t, m_sh, sh_t, m_boot;
    int exp_v;
    logic [31:0] exp_d;

    always @(posedge clk) begin
        int o_en, o_req, o_sh;
        if (rst) begin
            m_en = 0; m_req = 0; m_enp = 0; m_rdy = 0; rise_t = 0; fall_t = 0;
            m_sh = 0; sh_t = 0; m_boot = 0; exp_v = 0; exp_d = 0;
        end else begin
            o_en = m_en; o_req = m_req; o_sh = m_sh;
            exp_v = (bus_sel && !bus_wr) ? 1 : 0;
            exp_d = 0;
            if (exp_v == 1) begin
                if (bus_addr == 16'h0014)
                    exp_d = (32'(o_req) << 14) | 32'(o_en);
                else if (bus_addr == 16'h001C)
                    exp_d = (32'(o_sh) << 2) | 32'(m_rdy);
                else if (bus_addr == 16'h1300)
                    exp_d = (m_boot == BOOT_LAT) ? 32'hDE71CE55 : 32'h0;
            end
            // ready behaviour
            if (m_rdy == 0) begin
                if (rise_t > 0) begin
                    if (o_en == 0 || o_req != 0 || o_sh == 1) rise_t = 0;
                    else if (rise_t == 1) begin m_rdy = 1; rise_t = 0; end
                    else rise_t--;
                end else if (o_en == 1 && o_req == 0 && o_sh != 1) begin
                    rise_t = EN_LAT;
                end
            end else begin
                if (fall_t > 0) begin
                    if (o_en == 1) fall_t = 0;
                    else if (fall_t == 1) begin m_rdy = 0; fall_t = 0; end
                    else fall_t--;
                end else if (o_en == 0) begin
                    fall_t = DIS_LAT;
                end
            end
            // shutdown behaviour
            if (o_en == 1 && m_enp == 0 && o_req == 0) begin
                m_sh = 0; sh_t = 0;
            end else if (o_sh == 0) begin
                if (o_req == 1) begin m_sh = 1; sh_t = SHN_LAT; end
                else if (o_req == 2) begin m_sh = 1; sh_t = ABRT_LAT; end
            end else if (o_sh == 1) begin
                if (sh_t == 1) m_sh = 2;
                else sh_t--;
            end
            m_enp = o_en;
            if (bus_sel && bus_wr && bus_addr == 16'h0014) begin
                m_en  = int'(bus_wdata[0]);
                m_req = int'(bus_wdata[15:14]);
            end
            if (m_boot < BOOT_LAT) m_boot++;
        end
    end

    // compare every clock, away from the active edge
    always @(negedge clk) begin
        if (!rst && !finished) begin
            n_checks++;
            if (rsp_valid !== exp_v[0] || rsp_data !== exp_d) begin
                n_fail++;
                $display("FAIL %s: got valid=%0d data=%h, expected valid=%0d data=%h",
                         tag, rsp_valid, rsp_data, exp_v, exp_d);
            end
        end
    end

    task automatic wr_reg(input logic [15:0] a, input logic [31:0] d);
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
    endtask

    task automatic rd_reg(input logic [15:0] a);
        bus_sel = 1; bus_wr = 0; bus_addr = a; bus_wdata = '0;
        @(negedge clk);
    endtask

    task automatic poll(input logic [15:0] a, input int n);
        for (int i = 0; i < n; i++) rd_reg(a);
    endtask

    task automatic idle();
        bus_sel = 0; bus_wr = 0; bus_addr = '0; bus_wdata = '0;
        @(negedge clk);
    endtask

    localparam logic [15:0] CFG = 16'h0014;
    localparam logic [15:0] STS = 16'h001C;
    localparam logic [15:0] BOOT = 16'h1300;

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        // R1: reset values
        tag = "R1";
        rd_reg(CFG); rd_reg(STS); rd_reg(BOOT); idle();
        // R2: undecoded offsets and idle cycles
        tag = "R2";
        rd_reg(16'h0018); rd_reg(16'h0020); rd_reg(16'h1304); rd_reg(16'h0000);
        idle(); idle();
        // R3: only enable and request bits are stored
        tag = "R3";
        wr_reg(CFG, 32'hFFFF_3FFE); rd_reg(CFG);
        wr_reg(CFG, 32'h0000_C000); rd_reg(CFG);
        wr_reg(CFG, 32'h0); rd_reg(CFG); idle();
        // R10: boot word appears after BOOT_LAT edges
        tag = "R10";
        poll(BOOT, 16); idle();
        // R4: enable to ready latency
        tag = "R4";
        wr_reg(CFG, 32'h1); poll(STS, 10);
        // R11: writes to read-only and undecoded offsets are ignored
        tag = "R11";
        wr_reg(STS, 32'h0); wr_reg(BOOT, 32'h0); wr_reg(16'h0040, 32'hFFFF_FFFF);
        rd_reg(STS); rd_reg(BOOT); rd_reg(CFG); rd_reg(16'h0040);
        // R5: disable latency and re-enable inside the falling window
        tag = "R5";
        wr_reg(CFG, 32'h0); poll(STS, 2);
        wr_reg(CFG, 32'h1); poll(STS, 4);
        wr_reg(CFG, 32'h0); poll(STS, 6);
        // R6: aborted rise, and shutdown during a rise
        tag = "R6";
        wr_reg(CFG, 32'h1); poll(STS, 2);
        wr_reg(CFG, 32'h0); poll(STS, 8);
        wr_reg(CFG, 32'h1); poll(STS, 2);
        wr_reg(CFG, 32'h0000_4001); poll(STS, 12);
        // R9: fresh enable clears completed shutdown
        tag = "R9";
        wr_reg(CFG, 32'h0); poll(STS, 2);
        wr_reg(CFG, 32'h1); poll(STS, 10);
        // R7: normal shutdown with ready held
        tag = "R7";
        wr_reg(CFG, 32'h0000_4001); poll(STS, 10);
        // R8: abrupt shutdown, then reserved request
        tag = "R8";
        wr_reg(CFG, 32'h0); poll(STS, 5);
        wr_reg(CFG, 32'h1); poll(STS, 8);
        wr_reg(CFG, 32'h0000_8001); poll(STS, 6);
        wr_reg(CFG, 32'h0); poll(STS, 5);
        wr_reg(CFG, 32'h1); poll(STS, 8);
        wr_reg(CFG, 32'h0000_C001); poll(STS, 8);
        rd_reg(CFG); idle(); idle();
        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got running, expected finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule